// File: doc/BRIEF.md
# Reset Boot Load Sequencer

This block fills on-chip program memory automatically after reset and keeps the processor core stalled until that memory holds something worth running. The three mode pins are captured while reset is low. One setting selects a load from an external byte-wide memory. Another selects a load through the host port. Every other setting skips loading altogether.

In byte mode the sequencer starts with its external byte pointer and its internal word pointer at zero. It then reads the byte memory one address per cycle and joins each group of three bytes into one 24-bit program word. It writes a fixed count of words (32 by default) into program memory from address 0 upwards. Once the last word is written, it releases the core, which begins at program address 0.

In host mode the sequencer drives neither memory port. It watches the host write strobe and releases the core once a host write lands on program-memory location 0.

Top module: `boot_seq`

## Requirements
- R1: The mode pins `{C,B,A}` = `mode_pins[2:0]` are sampled only while `rst_n` is low. `3'b000` selects byte boot and `3'b101` selects host boot. A change on the pins after reset release has no effect.
- R2: While `rst_n` is low, and in the first cycle after its release, `core_hold`=1, `done`=0, `pm_we`=0 and `bm_rd`=0.
- R3: In byte boot, `bm_rd` is high for exactly 3×WORDS consecutive cycles, beginning in the second cycle after release. `bm_addr` starts at 0 and rises by one each cycle.
- R4: Program word w is `{byte(3w), byte(3w+1), byte(3w+2)}`, with the most significant byte first. Here byte(a) is `bm_data` presented while `bm_addr`=a.
- R5: In byte boot, `pm_we` pulses for one cycle per word, once every third cycle, exactly WORDS times. `pm_addr` runs 0, 1, … WORDS−1.
- R6: In byte boot, `core_hold` stays 1 until the last word has been written. In the following cycle `done`=1 and `core_hold`=0, and both stay that way until the next reset.
- R7: In host boot, `bm_rd` and `pm_we` stay 0. A host write with `hst_wr`=1, `hst_dm`=0 and `hst_addr`=0, sampled on a clock edge, sets `done` and clears `core_hold` in the next cycle.
- R8: In host boot, a host write to a nonzero address, or one with `hst_dm`=1 (data memory), leaves `core_hold`=1.
- R9: Any mode setting other than the two boot modes releases the core in the second cycle after reset release and performs no memory access.
- R10: Asserting reset part-way through a load abandons it. After the new release, the sequence restarts from address 0 under the newly sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pins | input | 3 | Boot mode selection `{C,B,A}` |
| bm_addr | output | BM_AW | External byte memory address |
| bm_rd | output | 1 | Byte memory read strobe |
| bm_data | input | 8 | Byte read at `bm_addr` (same cycle) |
| hst_wr | input | 1 | Host memory write strobe |
| hst_dm | input | 1 | Host write targets data memory (1) or program memory (0) |
| hst_addr | input | PM_AW | Host write address |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | PM_AW | Program memory write address |
| pm_wdata | output | 24 | Program memory write word |
| core_hold | output | 1 | Core execution held off |
| done | output | 1 | Boot finished, core runs from address 0 |

## Verification
The bench builds the block with WORDS=32, PM_AW=14 and BM_AW=16, which is the reset-default word count at full length. That choice puts the final word, the 96th byte read and the hand-off to execution within reach of a compare on every cycle. A position-dependent byte pattern makes any mix-up in byte order or address visible. The bench also interrupts a load with a second reset, and it covers host writes that must be ignored as well as the two mode settings that skip loading.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int WORDS = 32,
  parameter int PM_AW = 14,
  parameter int BM_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_pins,
  output logic [BM_AW-1:0] bm_addr,
  output logic             bm_rd,
  input  logic [7:0]       bm_data,
  input  logic             hst_wr,
  input  logic             hst_dm,
  input  logic [PM_AW-1:0] hst_addr,
  output logic             pm_we,
  output logic [PM_AW-1:0] pm_addr,
  output logic [23:0]      pm_wdata,
  output logic             core_hold,
  output logic             done
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [2:0] MODE_BYTE = 3'b000;
  localparam logic [2:0] MODE_HOST = 3'b101;

  typedef enum logic [2:0] {S_RST, S_LOAD, S_LAST, S_HOST, S_DONE} st_t;

  st_t              st;
  logic [2:0]       mode_q;
  logic [BM_AW-1:0] ext_ptr;
  logic [PM_AW-1:0] int_ptr;
  logic [CNT_W-1:0] left;
  logic [1:0]       bsel;
  logic [15:0]      acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RST;
      mode_q   <= mode_pins;
      ext_ptr  <= '0;
      int_ptr  <= '0;
      left     <= CNT_W'(WORDS);
      bsel     <= '0;
      acc      <= '0;
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
    end else begin
      pm_we <= 1'b0;
      case (st)
        S_RST:
          st <= (mode_q == MODE_BYTE) ? S_LOAD :
                (mode_q == MODE_HOST) ? S_HOST : S_DONE;
        S_LOAD: begin
          ext_ptr <= ext_ptr + 1'b1;
          if (bsel != 2'd2) begin
            acc  <= {acc[7:0], bm_data};
            bsel <= bsel + 2'd1;
          end else begin
            bsel     <= '0;
            pm_we    <= 1'b1;
            pm_addr  <= int_ptr;
            pm_wdata <= {acc, bm_data};
            int_ptr  <= int_ptr + 1'b1;
            left     <= left - 1'b1;
            if (left == CNT_W'(1)) st <= S_LAST;
          end
        end
        S_LAST: st <= S_DONE;
        S_HOST:
          if (hst_wr && !hst_dm && hst_addr == '0) st <= S_DONE;
        default: ;
      endcase
    end
  end

  assign bm_rd     = (st == S_LOAD);
  assign bm_addr   = ext_ptr;
  assign core_hold = (st != S_DONE);
  assign done      = (st == S_DONE);
endmodule

module boot_seq_chk #(
  parameter int PM_AW = 14,
  parameter int BM_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bm_rd,
  input logic [BM_AW-1:0] bm_addr,
  input logic             pm_we,
  input logic [PM_AW-1:0] pm_addr,
  input logic             core_hold,
  input logic             done
);
  // R2
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (core_hold && !done && !pm_we && !bm_rd));

  // R3
  byte_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rd && $past(bm_rd)) |-> (bm_addr == $past(bm_addr) + 1'b1));

  // R3
  read_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd |-> core_hold);

  // R5
  single_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !pm_we);

  // R5
  write_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we && $past(pm_we, 3)) |-> (pm_addr == $past(pm_addr, 3) + 1'b1));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind boot_seq boot_seq_chk #(.PM_AW(PM_AW), .BM_AW(BM_AW)) i_boot_seq_chk (.*);

// File: tb/test_boot_seq.sv
module test_boot_seq;
  localparam int WORDS = 32;
  localparam int PM_AW = 14;
  localparam int BM_AW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       mode_pins = 3'b000;
  logic [BM_AW-1:0] bm_addr;
  logic             bm_rd;
  logic [7:0]       bm_data;
  logic             hst_wr = 1'b0;
  logic             hst_dm = 1'b0;
  logic [PM_AW-1:0] hst_addr = '0;
  logic             pm_we;
  logic [PM_AW-1:0] pm_addr;
  logic [23:0]      pm_wdata;
  logic             core_hold;
  logic             done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] byte_at(int a);
    return 8'(((a * 29) + 7) ^ (a >> 3));
  endfunction

  assign bm_data = byte_at(int'(bm_addr));

  boot_seq #(.WORDS(WORDS), .PM_AW(PM_AW), .BM_AW(BM_AW)) i_boot_seq (.*);

  int       cyc = 0;
  logic [2:0] mode_m = 3'b000;
  bit       hdone = 0;
  bit       rst_seen = 0;
  bit       started = 0;

  always @(posedge clk) begin
    started <= 1;
    rst_seen <= rst_n;
    if (!rst_n) begin
      cyc = 0;
      mode_m = mode_pins;
      hdone = 0;
    end else begin
      if (mode_m == 3'b101 && cyc >= 1 && hst_wr && !hst_dm && hst_addr == '0)
        hdone = 1;
      cyc++;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cyc=%0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit ld, we, dn;
      int w;
      ld = 0; we = 0; dn = 0; w = 0;
      if (rst_seen) begin
        if (mode_m == 3'b000) begin
          ld = (cyc >= 1 && cyc <= 3 * WORDS);
          we = (cyc >= 4 && cyc <= 3 * WORDS + 1 && ((cyc - 4) % 3) == 0);
          w  = (cyc - 4) / 3;
          dn = (cyc >= 3 * WORDS + 2);
        end else if (mode_m == 3'b101) begin
          dn = hdone;
        end else begin
          dn = (cyc >= 1);
        end
      end
      if (!rst_seen) begin
        chk("R2", "hold", core_hold, 1);
        chk("R2", "done", done, 0);
        chk("R2", "pm_we", pm_we, 0);
        chk("R2", "bm_rd", bm_rd, 0);
      end else if (mode_m == 3'b000) begin
        chk("R3", "bm_rd", bm_rd, ld);
        if (ld) chk("R3", "bm_addr", bm_addr, cyc - 1);
        chk("R5", "pm_we", pm_we, we);
        if (we) begin
          chk("R5", "pm_addr", pm_addr, w);
          chk("R4", "pm_wdata", pm_wdata,
              {byte_at(3 * w), byte_at(3 * w + 1), byte_at(3 * w + 2)});
        end
        chk("R6", "done", done, dn);
        chk("R6", "hold", core_hold, !dn);
      end else if (mode_m == 3'b101) begin
        chk("R7", "bm_rd", bm_rd, 0);
        chk("R7", "pm_we", pm_we, 0);
        chk("R7", "done", done, dn);
        chk("R8", "hold", core_hold, !dn);
      end else begin
        chk("R9", "bm_rd", bm_rd, 0);
        chk("R9", "pm_we", pm_we, 0);
        chk("R9", "done", done, dn);
        chk("R9", "hold", core_hold, !dn);
      end
    end
  end

  task automatic do_reset(logic [2:0] m, int n);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pins = m;
    repeat (n) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_write(logic dm, logic [PM_AW-1:0] a);
    @(negedge clk);
    hst_wr = 1'b1; hst_dm = dm; hst_addr = a;
    @(negedge clk);
    hst_wr = 1'b0; hst_dm = 1'b0; hst_addr = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: change pins mid-load, no effect expected
    repeat (20) @(negedge clk);
    mode_pins = 3'b101;
    repeat (100) @(negedge clk);
    mode_pins = 3'b011;
    repeat (5) @(negedge clk);
    // R10: restart mid-load
    do_reset(3'b000, 4);
    repeat (40) @(negedge clk);
    do_reset(3'b000, 3);
    repeat (110) @(negedge clk);
    // R7, R8: host boot
    do_reset(3'b101, 3);
    repeat (4) @(negedge clk);
    host_write(1'b0, 14'd5);
    host_write(1'b1, 14'd0);
    host_write(1'b0, 14'd1);
    repeat (6) @(negedge clk);
    host_write(1'b0, 14'd0);
    repeat (6) @(negedge clk);
    // R9: other modes
    do_reset(3'b011, 3);
    repeat (8) @(negedge clk);
    do_reset(3'b001, 3);
    repeat (8) @(negedge clk);
    // R10: abandon host wait into byte boot
    do_reset(3'b101, 3);
    repeat (10) @(negedge clk);
    do_reset(3'b000, 3);
    repeat (105) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule